// File: doc/BRIEF.md
# Banked Accumulator Add Unit

This block executes the two byte-wide addition instructions of a small accumulator machine. It receives a 16-bit instruction word and completes each instruction in four clock phases: decode, operand read, add, commit. Throughout this block the accumulator is called W. The immediate form adds an 8-bit constant held in the instruction to W. The register form adds W to a byte in a banked data memory. A bit in the opcode then selects whether the sum goes back to W or replaces that byte.

The block contains W, the status flags, a bank pointer register and the data memory. A register-form operand address is either taken from a fixed window, the access window, or formed from the bank pointer and the 8-bit file field. The bank pointer is not a separate port. It occupies a fixed byte address in the top bank, so the register form itself reads and writes it. Fetch, the program counter and all other opcodes belong to the surrounding core.

Top module: `acc_add_unit`

## Requirements
- R1: A synchronous reset clears W, the flags, the bank pointer and every data memory byte, and sets the phase to 0. The reset state shows on the outputs one edge after reset is sampled high.
- R2: `phase_o` counts 0, 1, 2, 3 and wraps to 0, advancing by one on every clock edge out of reset. An instruction is sampled on the edge taken while the phase is 0. Its results show on the outputs after the fourth edge, when the phase is 0 again.
- R3: When `instr_i[15:8]` is 0x0F (immediate add), W becomes the 8-bit sum of W and `instr_i[7:0]`.
- R4: When `instr_i[15:10]` is 0b001001 (register add) and bit 9 (destination) is 0, W becomes the sum of W and the addressed byte. The byte keeps its value.
- R5: For a register add with bit 9 set, the sum is stored into the addressed byte and W keeps its value.
- R6: For a register add with bit 8 clear, file addresses 0x00–0x7F select bank 0 and 0x80–0xFF select the top bank (bank 7 by default).
- R7: For a register add with bit 8 set, the bank is the value of the bank pointer and the file field `instr_i[7:0]` gives the offset.
- R8: The bank pointer sits at offset 0xE0 of the top bank. A read of it returns its value zero-extended to 8 bits. A write to it keeps the low three bits of the sum.
- R9: `flags_o` bit 0 is carry out of bit 7 and bit 1 is carry out of bit 3. Both instructions update all five flags.
- R10: `flags_o` bit 2 is set when the 8-bit sum is 0x00. Bit 4 equals bit 7 of the sum.
- R11: `flags_o` bit 3 is set when both addends share a sign bit and the sum's sign bit differs from it.
- R12: Any other instruction word still takes four phases and changes no W, flag, bank pointer or memory state.
- R13: W and the flags change only on the edge that ends phase 3. They hold their values during phases 1 to 3 of the next instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| instr_i | input | 16 | Instruction word, sampled in phase 0 |
| phase_o | output | 2 | Current phase, 0 to 3 |
| w_o | output | 8 | Accumulator W |
| flags_o | output | 5 | {negative, overflow, zero, digit carry, carry} |

## Verification
The bench presents a word on a falling edge while `phase_o` is 0. Four rising edges later the phase has wrapped to 0 and W and the flags for that word are due. The monitor samples a quarter period after each rising edge. It compares the front entry of the scoreboard queue only at that phase-0 sample, and during phases 1 to 3 it requires the previously committed W to be unchanged. Memory bytes and the bank pointer are observed by reading them into a W that has first been brought to zero.

// File: rtl/acc_add_pkg.sv
package acc_add_pkg;
   typedef enum logic [1:0] {
      PH_DECODE = 2'd0,
      PH_READ   = 2'd1,
      PH_EXEC   = 2'd2,
      PH_WRITE  = 2'd3
   } phase_e;

   typedef enum logic [1:0] {
      OP_NOP = 2'd0,
      OP_LIT = 2'd1,
      OP_REG = 2'd2
   } op_e;

   typedef struct packed {
      logic neg;
      logic ovf;
      logic zero;
      logic dcy;
      logic cy;
   } flags_t;

   localparam logic [7:0] LIT_OPC = 8'h0F;
   localparam logic [5:0] REG_OPC = 6'b001001;
endpackage

// File: rtl/acc_phase_seq.sv
module acc_phase_seq
   import acc_add_pkg::*;
(
   input  logic   clk_i,
   input  logic   rst_i,
   output phase_e phase_o
);
   phase_e phase_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) phase_q <= PH_DECODE;
      else       phase_q <= phase_e'(2'(phase_q + 2'd1));
   end

   assign phase_o = phase_q;

   // R2: one phase step per edge, wrapping after phase 3
   assert_phase_step_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      !rst_i |=> (phase_q == phase_e'(2'($past(phase_q) + 2'd1))));
endmodule

// File: rtl/acc_addr_map.sv
module acc_addr_map #(
   parameter int unsigned BANK_BITS    = 3,
   parameter logic [7:0]  ACCESS_SPLIT = 8'h80
) (
   input  logic [7:0]           file_i,
   input  logic                 banked_i,
   input  logic [BANK_BITS-1:0] bsr_i,
   output logic [BANK_BITS+7:0] addr_o
);
   localparam logic [BANK_BITS-1:0] TOP_BANK = '1;
   localparam logic [BANK_BITS-1:0] LOW_BANK = '0;

   logic [BANK_BITS-1:0] access_bank;

   generate
      if (ACCESS_SPLIT == 8'h00) begin : g_all_top
         assign access_bank = TOP_BANK;
      end else begin : g_split
         assign access_bank = (file_i < ACCESS_SPLIT) ? LOW_BANK : TOP_BANK;
      end
   endgenerate

   assign addr_o = banked_i ? {bsr_i, file_i} : {access_bank, file_i};
endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import acc_add_pkg::*;
(
   input  logic [7:0] a_i,
   input  logic [7:0] b_i,
   output logic [7:0] sum_o,
   output flags_t     flags_o
);
   logic [4:0] low_nib;
   logic [8:0] full;

   always_comb begin
      low_nib       = {1'b0, a_i[3:0]} + {1'b0, b_i[3:0]};
      full          = {1'b0, a_i} + {1'b0, b_i};
      sum_o         = full[7:0];
      flags_o.cy    = full[8];
      flags_o.dcy   = low_nib[4];
      flags_o.zero  = (full[7:0] == 8'h00);
      flags_o.neg   = full[7];
      flags_o.ovf   = (a_i[7] == b_i[7]) && (full[7] != a_i[7]);
   end
endmodule

// File: rtl/acc_data_ram.sv
module acc_data_ram #(
   parameter int unsigned AW = 11
) (
   input  logic          clk_i,
   input  logic          clr_i,
   input  logic          we_i,
   input  logic [AW-1:0] waddr_i,
   input  logic [7:0]    wdata_i,
   input  logic [AW-1:0] raddr_i,
   output logic [7:0]    rdata_o
);
   localparam int unsigned DEPTH = 1 << AW;

   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk_i) begin
      if (clr_i) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we_i) begin
         mem[waddr_i] <= wdata_i;
      end
   end

   assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/acc_add_unit.sv
module acc_add_unit
   import acc_add_pkg::*;
#(
   parameter int unsigned BANK_BITS    = 3,
   parameter logic [7:0]  ACCESS_SPLIT = 8'h80,
   parameter logic [7:0]  BSR_OFFSET   = 8'hE0,
   parameter bit          RAM_CLEAR    = 1'b1
) (
   input  logic        clk_i,
   input  logic        rst_i,
   input  logic [15:0] instr_i,
   output logic [1:0]  phase_o,
   output logic [7:0]  w_o,
   output logic [4:0]  flags_o
);
   localparam int unsigned          AW       = BANK_BITS + 8;
   localparam logic [BANK_BITS-1:0] TOP_BANK = '1;
   localparam logic [AW-1:0]        BSR_ADDR = {TOP_BANK, BSR_OFFSET};

   generate
      if (BANK_BITS < 1 || BANK_BITS > 4) begin : g_bad_banks
         $error("acc_add_unit: BANK_BITS must lie in 1..4");
      end
   endgenerate

   phase_e               phase;
   op_e                  op_c, op_q;
   logic [7:0]           arg_q;
   logic                 dest_q, banked_q;
   logic [AW-1:0]        addr_c, addr_q;
   logic [7:0]           opnd_q, res_q, sum_c, ram_rd, w_q, bsr_byte;
   flags_t               fl_c, rfl_q, flags_q;
   logic [BANK_BITS-1:0] bsr_q;
   logic                 ram_we, ram_clr;

   acc_phase_seq u_seq (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .phase_o (phase)
   );

   acc_addr_map #(
      .BANK_BITS    (BANK_BITS),
      .ACCESS_SPLIT (ACCESS_SPLIT)
   ) u_map (
      .file_i   (arg_q),
      .banked_i (banked_q),
      .bsr_i    (bsr_q),
      .addr_o   (addr_c)
   );

   acc_alu u_alu (
      .a_i     (w_q),
      .b_i     (opnd_q),
      .sum_o   (sum_c),
      .flags_o (fl_c)
   );

   generate
      if (RAM_CLEAR) begin : g_ram_clear
         assign ram_clr = rst_i;
      end else begin : g_ram_keep
         assign ram_clr = 1'b0;
      end
   endgenerate

   acc_data_ram #(.AW(AW)) u_ram (
      .clk_i   (clk_i),
      .clr_i   (ram_clr),
      .we_i    (ram_we),
      .waddr_i (addr_q),
      .wdata_i (res_q),
      .raddr_i (addr_c),
      .rdata_o (ram_rd)
   );

   assign bsr_byte = 8'(bsr_q);

   always_comb begin
      if (instr_i[15:8] == LIT_OPC)       op_c = OP_LIT;
      else if (instr_i[15:10] == REG_OPC) op_c = OP_REG;
      else                                op_c = OP_NOP;
   end

   assign ram_we = (phase == PH_WRITE) && (op_q == OP_REG) && dest_q && (addr_q != BSR_ADDR);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         op_q     <= OP_NOP;
         arg_q    <= '0;
         dest_q   <= 1'b0;
         banked_q <= 1'b0;
         addr_q   <= '0;
         opnd_q   <= '0;
         res_q    <= '0;
         rfl_q    <= '0;
         w_q      <= '0;
         flags_q  <= '0;
         bsr_q    <= '0;
      end else begin
         case (phase)
            PH_DECODE: begin
               op_q     <= op_c;
               arg_q    <= instr_i[7:0];
               dest_q   <= instr_i[9];
               banked_q <= instr_i[8];
            end
            PH_READ: begin
               addr_q <= addr_c;
               if (op_q == OP_LIT)          opnd_q <= arg_q;
               else if (addr_c == BSR_ADDR) opnd_q <= bsr_byte;
               else                         opnd_q <= ram_rd;
            end
            PH_EXEC: begin
               res_q <= sum_c;
               rfl_q <= fl_c;
            end
            default: begin
               if (op_q == OP_LIT) begin
                  w_q     <= res_q;
                  flags_q <= rfl_q;
               end else if (op_q == OP_REG) begin
                  flags_q <= rfl_q;
                  if (!dest_q)                 w_q   <= res_q;
                  else if (addr_q == BSR_ADDR) bsr_q <= res_q[BANK_BITS-1:0];
               end
            end
         endcase
      end
   end

   assign phase_o = phase;
   assign w_o     = w_q;
   assign flags_o = flags_q;

   // R1: reset state one edge after reset
   assert_reset_state_R1: assert property (@(posedge clk_i)
      rst_i |=> (phase == PH_DECODE && w_q == 8'h00 && flags_q == '0 && bsr_q == '0));

   // R13: architectural state only moves on the commit edge
   assert_hold_outside_write_R13: assert property (@(posedge clk_i) disable iff (rst_i)
      (phase != PH_WRITE) |=> ($stable(w_q) && $stable(flags_q) && $stable(bsr_q)));

   // R3: immediate add commits W plus literal
   assert_lit_sum_R3: assert property (@(posedge clk_i) disable iff (rst_i)
      (phase == PH_WRITE && op_q == OP_LIT) |=> (w_q == 8'($past(w_q) + $past(arg_q))));

   // R5: register destination leaves W alone
   assert_dest_reg_keeps_w_R5: assert property (@(posedge clk_i) disable iff (rst_i)
      (phase == PH_WRITE && op_q == OP_REG && dest_q) |=> $stable(w_q));

   // R12: unknown words leave all state untouched
   assert_nop_quiet_R12: assert property (@(posedge clk_i) disable iff (rst_i)
      (phase == PH_WRITE && op_q == OP_NOP) |=> ($stable(w_q) && $stable(flags_q) && $stable(bsr_q)));
endmodule

// File: tb/test_acc_add_unit.sv
module test_acc_add_unit;
   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic [7:0] w;
      logic [4:0] f;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] instr = 16'h0000;
   logic [1:0]  phase;
   logic [7:0]  w;
   logic [4:0]  flags;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   exp_t  exp_q [$];
   string req_q [$];

   logic [7:0] m_ram [0:2047];
   logic [7:0] m_w;
   logic [4:0] m_f;
   logic [2:0] m_bsr;
   logic [7:0] w_last;
   logic [1:0] ph_prev;
   bit         ph_valid = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   acc_add_unit i_acc_add_unit (
      .clk_i   (clk),
      .rst_i   (rst),
      .instr_i (instr),
      .phase_o (phase),
      .w_o     (w),
      .flags_o (flags)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [4:0] spec_flags(input logic [7:0] x, input logic [7:0] y);
      logic [8:0] s;
      logic       c, dc, z, n, ov;
      s  = 9'(x) + 9'(y);
      c  = (s > 9'd255);
      dc = ((5'(x[3:0]) + 5'(y[3:0])) > 5'd15);
      z  = (s[7:0] == 8'h00);
      n  = s[7];
      ov = (x[7] == y[7]) && (s[7] != x[7]);
      return {n, ov, z, dc, c};
   endfunction

   function automatic logic [15:0] lit(input logic [7:0] k);
      return {8'h0F, k};
   endfunction

   function automatic logic [15:0] regop(input logic [7:0] f, input logic d, input logic a);
      return {6'b001001, d, a, f};
   endfunction

   task automatic model_reset();
      m_w = 8'h00; m_f = 5'h00; m_bsr = 3'd0;
      for (int i = 0; i < 2048; i++) m_ram[i] = 8'h00;
   endtask

   task automatic issue(input logic [15:0] ins, input string req);
      logic [7:0] opnd, s, f;
      logic [2:0] bank;
      logic       is_bsr;
      exp_t       e;
      @(negedge clk);
      while (phase != 2'd0) @(negedge clk);
      if (ins[15:8] == 8'h0F) begin
         opnd = ins[7:0];
         s = m_w + opnd;
         m_f = spec_flags(m_w, opnd);
         m_w = s;
      end else if (ins[15:10] == 6'b001001) begin
         f      = ins[7:0];
         bank   = ins[8] ? m_bsr : (f >= 8'h80 ? 3'd7 : 3'd0);
         is_bsr = (bank == 3'd7) && (f == 8'hE0);
         opnd   = is_bsr ? {5'b0, m_bsr} : m_ram[{bank, f}];
         s      = m_w + opnd;
         m_f    = spec_flags(m_w, opnd);
         if (!ins[9])     m_w = s;
         else if (is_bsr) m_bsr = s[2:0];
         else             m_ram[{bank, f}] = s;
      end
      instr = ins;
      e.w = m_w;
      e.f = m_f;
      exp_q.push_back(e);
      req_q.push_back(req);
   endtask

   task automatic set_w(input logic [7:0] v);
      issue(lit(8'(v - m_w)), "R3");
   endtask

   // Monitor: compare at the phase-0 sample that follows each commit
   initial begin
      w_last = 8'h00;
      forever begin
         @(posedge clk);
         #(CLK_PERIOD/4);
         if (rst) begin
            ph_valid = 1'b0;
            w_last = 8'h00;
         end else begin
            if (ph_valid) check("R2 phase step", 16'(phase), 16'(2'(ph_prev + 2'd1)));
            ph_prev  = phase;
            ph_valid = 1'b1;
            if (phase == 2'd0 && exp_q.size() > 0) begin
               exp_t  e;
               string r;
               e = exp_q.pop_front();
               r = req_q.pop_front();
               check({r, " W"}, 16'(w), 16'(e.w));
               check({r, " flags"}, 16'(flags), 16'(e.f));
               w_last = e.w;
            end else if (phase != 2'd0) begin
               check("R13 W held mid-instruction", 16'(w), 16'(w_last));
            end
         end
      end
   end

   // Watchdog
   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst = 1'b0;
      #1;
      // R1 reset values
      check("R1 W after reset", 16'(w), 16'h0000);
      check("R1 flags after reset", 16'(flags), 16'h0000);
      check("R1 phase after reset", 16'(phase), 16'h0000);

      issue(lit(8'h10), "R3");
      issue(lit(8'h15), "R3");               // W = 0x25
      issue(lit(8'hDB), "R9 carry/digit carry/zero"); // 0x25+0xDB = 0x100

      set_w(8'hC2);
      issue(regop(8'h20, 1'b1, 1'b0), "R5"); // bank0[0x20] = 0xC2
      set_w(8'h17);
      issue(regop(8'h20, 1'b0, 1'b0), "R4"); // W = 0xD9
      set_w(8'h00);
      issue(regop(8'h20, 1'b0, 1'b0), "R4 register kept"); // W = 0xC2

      set_w(8'h3C);
      issue(regop(8'h90, 1'b1, 1'b0), "R6 upper access half");
      set_w(8'h07);
      issue(regop(8'hE0, 1'b1, 1'b0), "R8 bank pointer write");
      set_w(8'h00);
      issue(regop(8'hE0, 1'b0, 1'b0), "R8 bank pointer read");
      set_w(8'h00);
      issue(regop(8'h90, 1'b0, 1'b1), "R7 banked read top bank");

      set_w(8'hFB);
      issue(regop(8'hE0, 1'b1, 1'b0), "R8 bank pointer truncation");
      set_w(8'h5A);
      issue(regop(8'h20, 1'b1, 1'b1), "R7 banked write");
      set_w(8'h00);
      issue(regop(8'h20, 1'b0, 1'b0), "R6 lower access half");
      set_w(8'h00);
      issue(regop(8'h20, 1'b0, 1'b1), "R7 banked read bank 2");

      set_w(8'h70);
      issue(lit(8'h20), "R11 positive overflow");
      set_w(8'h80);
      issue(lit(8'h80), "R11 negative overflow");
      set_w(8'hF0);
      issue(lit(8'h05), "R10 negative no overflow");
      set_w(8'h08);
      issue(lit(8'h08), "R9 digit carry");

      issue(16'hFFFF, "R12");
      issue(16'h0E55, "R12");
      issue(16'h2855, "R12");
      issue(16'h0000, "R12");
      set_w(8'h00);
      issue(regop(8'hE0, 1'b0, 1'b0), "R12 bank pointer intact");

      // Reset in mid-run (R1)
      wait (exp_q.size() == 0);
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      model_reset();
      #1;
      check("R1 W after second reset", 16'(w), 16'h0000);
      check("R1 flags after second reset", 16'(flags), 16'h0000);
      check("R1 phase after second reset", 16'(phase), 16'h0000);
      issue(regop(8'h20, 1'b0, 1'b0), "R1 memory cleared");
      issue(regop(8'hE0, 1'b0, 1'b0), "R1 bank pointer cleared");

      wait (exp_q.size() == 0);
      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule